// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets any core in a cluster of `NUM_CORES` cores raise an interrupt on any other core, itself included. Cores talk to it through a single command port that carries the issuing core's index, a two-bit opcode and a one-core-index argument. A fixed-priority selector in front of the block, outside it, hands over at most one command per cycle. Inside, a square matrix of pending bits is indexed by sender and target. Each target gets one IRQ line, driven by the OR of its column in the matrix.

Several cores can interrupt the same target before it responds. Their requests then merge onto the target's one IRQ line. The target issues a source query to read a mask that has one bit per sender. It then acknowledges each sender with its own command, and its line drops once the last of them is acknowledged. A sender can poll whether its previous interrupt to a given target is still outstanding. This lets software refuse to send again until that interrupt is serviced. Results of both query commands land in one shared readback register. A one-cycle event pulse per target marks each send that newly sets a pending bit.

Top module: `ipi_ctrl`

## Requirements
- R1: While reset is low at a clock edge, every pending bit is cleared. After that edge `irq_o`, `send_evt_o` and `readback_o` read zero.
- R2: Send is opcode 2'b00. With `cmd_valid` high it sets the pending bit for pair (issuing core `cmd_core`, target `cmd_arg`), so `irq_o[cmd_arg]` is high in the cycle after the command.
- R3: `send_evt_o[t]` pulses high for exactly the cycle after a send to target t whose pending bit was clear. A send that finds its bit already set leaves the bit set and produces no pulse.
- R4: Status query is opcode 2'b10. It loads the readback register with 1 in bit 0 if the pair (issuing core, target `cmd_arg`) is pending, and with 0 otherwise. All other bits are zero.
- R5: Source query is opcode 2'b11. It loads the readback register with a mask whose bit s is 1 exactly when sender s has a pending interrupt to the issuing core.
- R6: When two or more cores have sent to the same target, that target's single IRQ line is high, and its source mask has one bit set for each of those senders.
- R7: Acknowledge is opcode 2'b01. It clears only the pending bit from sender `cmd_arg` to the issuing core. Every other pair is unchanged, and acknowledging a pair that is not pending changes nothing.
- R8: `irq_o[t]` stays high while any sender to t is still pending, and falls in the cycle after the last of them is acknowledged.
- R9: The readback register changes only in the cycle after a query command (opcode 2'b10 or 2'b11). It holds its value through sends, acknowledges and idle cycles.
- R10: With `cmd_valid` low, no pending bit, IRQ line or readback value changes, whatever the other command inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_core | input | CORE_W | Index of the core issuing the command |
| cmd_op | input | 2 | Opcode: 00 send, 01 acknowledge, 10 status query, 11 source query |
| cmd_arg | input | CORE_W | Target core (send, status query) or sender core (acknowledge) |
| readback_o | output | NUM_CORES | Result of the most recent query command |
| irq_o | output | NUM_CORES | One interrupt line per target core |
| send_evt_o | output | NUM_CORES | One-cycle pulse per target on a newly set pending bit |

## Verification
Only one command arrives per cycle, so the overlaps that matter fall on one clock edge. A write can update the matrix on the same edge that a query reads it, and a new send can arrive on the same edge at which an acknowledge of the same column lands. The bench issues sends and acknowledges back to back, then queries the same pair or column in the very next cycle. Every readback, IRQ line and event pulse is compared with a bench model that updates the matrix before it evaluates the following command. The random phase mixes all four opcodes over a few cores, with idle cycles in between, so that merged sends, repeated sends and stray acknowledges meet queries at every distance.

// File: rtl/ipi_pkg.sv
// Shared opcode encoding for the inter-processor interrupt controller.
package ipi_pkg;

    // Command opcodes carried on cmd_op
    typedef enum logic [1:0] {
        OP_SEND   = 2'b00,
        OP_ACK    = 2'b01,
        OP_QUERY  = 2'b10,
        OP_SOURCE = 2'b11
    } ipi_op_e;

    // Decoded command strobes, at most one high
    typedef struct packed {
        logic is_send;
        logic is_ack;
        logic is_query;
        logic is_source;
    } ipi_dec_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
// Command decoder. It turns one command (issuer, opcode, argument) into
// per-cell set and clear strobes for the pending matrix and into query strobes.
// Assumes at most one command per cycle. Indices outside the core count are
// dropped. Cell index = sender * NUM_CORES + target.
module ipi_cmd_decode #(
    parameter  int NUM_CORES = 4,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CELLS     = NUM_CORES * NUM_CORES
) (
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CORE_W-1:0] cmd_core,
    input  logic [CORE_W-1:0] cmd_arg,
    output logic [CELLS-1:0]  set_vec,
    output logic [CELLS-1:0]  clr_vec,
    output logic              do_query,
    output logic              do_source
);
    import ipi_pkg::*;

    ipi_dec_t dec;
    logic     core_ok;
    logic     arg_ok;

    // Opcode decode gated by valid
    always_comb begin
        dec           = '0;
        dec.is_send   = cmd_valid && (cmd_op == OP_SEND);
        dec.is_ack    = cmd_valid && (cmd_op == OP_ACK);
        dec.is_query  = cmd_valid && (cmd_op == OP_QUERY);
        dec.is_source = cmd_valid && (cmd_op == OP_SOURCE);
    end

    // Range checks on the index fields
    always_comb begin
        core_ok = (int'(cmd_core) < NUM_CORES);
        arg_ok  = (int'(cmd_arg) < NUM_CORES);
    end

    // Per-cell strobes: send sets (issuer, arg), ack clears (arg, issuer)
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int s = 0; s < NUM_CORES; s++) begin
            for (int t = 0; t < NUM_CORES; t++) begin
                set_vec[s*NUM_CORES+t] = dec.is_send && core_ok && arg_ok &&
                                         (int'(cmd_core) == s) && (int'(cmd_arg) == t);
                clr_vec[s*NUM_CORES+t] = dec.is_ack && core_ok && arg_ok &&
                                         (int'(cmd_arg) == s) && (int'(cmd_core) == t);
            end
        end
    end

    // Query strobes, with the issuer checked for range
    always_comb begin
        do_query  = dec.is_query && core_ok;
        do_source = dec.is_source && core_ok;
    end

endmodule

// File: rtl/ipi_pending_matrix.sv
// Sender-by-target pending matrix. It holds one bit per cell, drives one IRQ
// line per target as the OR of its column, and registers one event pulse per
// target when a send sets a bit that was clear. Assumes set and clear never hit
// the same cell in one cycle. Synchronous active-low reset.
module ipi_pending_matrix #(
    parameter  int NUM_CORES = 4,
    localparam int CELLS     = NUM_CORES * NUM_CORES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CELLS-1:0]     set_vec,
    input  logic [CELLS-1:0]     clr_vec,
    output logic [CELLS-1:0]     pend,
    output logic [NUM_CORES-1:0] irq,
    output logic [NUM_CORES-1:0] new_evt
);
    logic [CELLS-1:0]     fresh;
    logic [NUM_CORES-1:0] fresh_col;

    // One storage cell per (sender, target) pair
    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        // Set wins over hold; clear only when no set targets the cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (set_vec[g])
                pend[g] <= 1'b1;
            else if (clr_vec[g])
                pend[g] <= 1'b0;
        end
    end

    // A set counts as new only when the cell was clear
    always_comb fresh = set_vec & ~pend;

    // Column reductions: IRQ per target and new-set flag per target
    always_comb begin
        irq       = '0;
        fresh_col = '0;
        for (int t = 0; t < NUM_CORES; t++) begin
            for (int s = 0; s < NUM_CORES; s++) begin
                irq[t]       = irq[t] | pend[s*NUM_CORES+t];
                fresh_col[t] = fresh_col[t] | fresh[s*NUM_CORES+t];
            end
        end
    end

    // Register the event so it lines up with the new pending bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            new_evt <= '0;
        else
            new_evt <= fresh_col;
    end

endmodule

// File: rtl/ipi_readback.sv
// Shared readback register. A status query loads 1 in bit 0 when the pair
// (issuer, target) is pending. A source query loads the issuer's pending column
// as a sender mask. The value holds until the next query. Assumes the issuer
// index has been range-checked upstream.
module ipi_readback #(
    parameter  int NUM_CORES = 4,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CELLS     = NUM_CORES * NUM_CORES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 do_query,
    input  logic                 do_source,
    input  logic [CORE_W-1:0]    cmd_core,
    input  logic [CORE_W-1:0]    cmd_arg,
    input  logic [CELLS-1:0]     pend,
    output logic [NUM_CORES-1:0] rb
);
    logic                 pair_hit;
    logic [NUM_CORES-1:0] src_mask;

    // Select the addressed pair and the issuer's column
    always_comb begin
        pair_hit = 1'b0;
        src_mask = '0;
        for (int s = 0; s < NUM_CORES; s++) begin
            for (int t = 0; t < NUM_CORES; t++) begin
                if (int'(cmd_core) == s && int'(cmd_arg) == t)
                    pair_hit = pend[s*NUM_CORES+t];
                if (int'(cmd_core) == t)
                    src_mask[s] = pend[s*NUM_CORES+t];
            end
        end
    end

    // Load on query commands only, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rb <= '0;
        else if (do_query)
            rb <= {{(NUM_CORES-1){1'b0}}, pair_hit};
        else if (do_source)
            rb <= src_mask;
    end

endmodule

// File: rtl/ipi_ctrl.sv
// Top of the inter-processor interrupt controller. It accepts one command per
// cycle from an external fixed-priority selector and keeps a sender-by-target
// pending matrix. It drives one IRQ line and one event pulse per target and
// answers queries through one readback register. Synchronous active-low reset.
module ipi_ctrl #(
    parameter  int NUM_CORES = 4,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [CORE_W-1:0]    cmd_core,
    input  logic [1:0]           cmd_op,
    input  logic [CORE_W-1:0]    cmd_arg,
    output logic [NUM_CORES-1:0] readback_o,
    output logic [NUM_CORES-1:0] irq_o,
    output logic [NUM_CORES-1:0] send_evt_o
);
    localparam int CELLS = NUM_CORES * NUM_CORES;

    logic [CELLS-1:0] set_vec;
    logic [CELLS-1:0] clr_vec;
    logic [CELLS-1:0] pend;
    logic             do_query;
    logic             do_source;

    ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_core  (cmd_core),
        .cmd_arg   (cmd_arg),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .do_query  (do_query),
        .do_source (do_source)
    );

    ipi_pending_matrix #(.NUM_CORES(NUM_CORES)) u_matrix (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend),
        .irq     (irq_o),
        .new_evt (send_evt_o)
    );

    ipi_readback #(.NUM_CORES(NUM_CORES)) u_readback (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_query  (do_query),
        .do_source (do_source),
        .cmd_core  (cmd_core),
        .cmd_arg   (cmd_arg),
        .pend      (pend),
        .rb        (readback_o)
    );

endmodule

// File: rtl/ipi_ctrl_checker.sv
// Port-level protocol checks for ipi_ctrl, attached through bind.
// Assumes the synchronous active-low reset of the design.
module ipi_ctrl_checker #(
    parameter  int NUM_CORES = 4,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [CORE_W-1:0]    cmd_core,
    input logic [1:0]           cmd_op,
    input logic [CORE_W-1:0]    cmd_arg,
    input logic [NUM_CORES-1:0] readback_o,
    input logic [NUM_CORES-1:0] irq_o,
    input logic [NUM_CORES-1:0] send_evt_o
);
    logic rst_seen = 1'b0;

    // Flag set by a clock edge that saw reset low
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1: after a reset edge all outputs are zero
    always @(negedge clk) begin
        if (rst_seen) begin
            assert_reset_clear_R1: assert (irq_o == '0 && send_evt_o == '0 && readback_o == '0)
                else $error("reset did not clear outputs");
        end
    end

    // R2: a valid send raises the target's line next cycle
    assert_send_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00 && int'(cmd_core) < NUM_CORES && int'(cmd_arg) < NUM_CORES)
        |=> irq_o[$past(cmd_arg)]);

    // R3: an event pulse only follows a send command
    assert_evt_needs_send_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (send_evt_o != '0) |-> ($past(cmd_valid) && $past(cmd_op) == 2'b00 && $onehot0(send_evt_o)));

    // R4: status query leaves upper readback bits zero
    assert_query_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10) |=> (readback_o >> 1) == '0);

    // R9: readback holds unless a query was issued
    assert_rb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op[1]) |=> $stable(readback_o));

    // R10: idle cycles leave the IRQ lines untouched
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(irq_o));

    // R7: an acknowledge can only move the issuer's own line
    for (genvar t = 0; t < NUM_CORES; t++) begin : g_ack
        assert_ack_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == 2'b01 && int'(cmd_core) != t) |=> $stable(irq_o[t]));
    end

endmodule

bind ipi_ctrl ipi_ctrl_checker #(.NUM_CORES(NUM_CORES)) u_ipi_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_core   (cmd_core),
    .cmd_op     (cmd_op),
    .cmd_arg    (cmd_arg),
    .readback_o (readback_o),
    .irq_o      (irq_o),
    .send_evt_o (send_evt_o)
);

// File: tb/ipi_ctrl_test.sv
// Self-checking bench for ipi_ctrl: directed corner cases, then seeded random
// commands, all compared against a bench-side model of the pending matrix.
module ipi_ctrl_test;
    localparam int N       = 4;
    localparam int CW      = 2;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [CW-1:0] cmd_core = '0;
    logic [1:0]    cmd_op = '0;
    logic [CW-1:0] cmd_arg = '0;
    logic [N-1:0]  readback_o, irq_o, send_evt_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  pm [N][N];
    logic [N-1:0] m_rb = '0;
    logic [N-1:0] m_evt = '0;

    always #(CLK_PER/2) clk = ~clk;

    ipi_ctrl #(.NUM_CORES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_core(cmd_core),
        .cmd_op(cmd_op), .cmd_arg(cmd_arg), .readback_o(readback_o),
        .irq_o(irq_o), .send_evt_o(send_evt_o)
    );

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] v = '0;
        for (int t = 0; t < N; t++)
            for (int s = 0; s < N; s++)
                if (pm[s][t]) v[t] = 1'b1;
        return v;
    endfunction

    function automatic logic [N-1:0] exp_src(int me);
        logic [N-1:0] v = '0;
        for (int s = 0; s < N; s++) v[s] = pm[s][me];
        return v;
    endfunction

    task automatic cmp(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        cmp(req, "irq", irq_o, exp_irq());
        cmp(req, "readback", readback_o, m_rb);
        cmp(req, "event", send_evt_o, m_evt);
    endtask

    // Drive one cycle at a falling edge, update the model, compare at the next falling edge
    task automatic step(bit v, int core, int op, int arg, string req);
        cmd_valid = v;
        cmd_core  = CW'(core);
        cmd_op    = 2'(op);
        cmd_arg   = CW'(arg);
        @(negedge clk);
        m_evt = '0;
        if (v) begin
            case (op)
                0: begin
                    if (!pm[core][arg]) m_evt[arg] = 1'b1;
                    pm[core][arg] = 1'b1;
                end
                1: pm[arg][core] = 1'b0;
                2: m_rb = {{(N-1){1'b0}}, pm[core][arg]};
                default: m_rb = exp_src(core);
            endcase
        end
        check_all(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        for (int s = 0; s < N; s++)
            for (int t = 0; t < N; t++) pm[s][t] = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        step(1, 1, 0, 2, "R2");              // first send: line and event
        step(1, 1, 0, 2, "R3");              // repeat send: no new event
        step(1, 0, 0, 2, "R6");              // second sender, same target
        step(1, 3, 0, 2, "R6");              // third sender
        step(1, 2, 3, 0, "R5");              // source mask 1011
        cmp("R6", "mask", readback_o, 4'b1011);
        step(1, 1, 2, 2, "R4");              // own pair pending -> 1
        step(1, 0, 2, 3, "R4");              // nothing to core 3 -> 0
        step(0, 2, 1, 1, "R10");             // invalid ack ignored
        step(1, 1, 0, 3, "R9");              // send, readback holds
        step(1, 2, 1, 0, "R7");              // target 2 acks sender 0
        step(1, 2, 3, 0, "R8");              // line still up, mask 1010
        step(1, 3, 1, 2, "R7");              // ack of a clear pair: no change
        step(1, 2, 1, 1, "R8");
        step(1, 2, 1, 3, "R8");              // last sender acked: line drops
        cmp("R8", "irq2", {3'b000, irq_o[2]}, 4'b0000);
        step(1, 1, 2, 2, "R4");              // own pair cleared -> 0
        step(1, 3, 1, 1, "R7");              // clear pair 1->3
        step(1, 3, 0, 3, "R2");              // self send
        step(1, 3, 2, 3, "R4");

        for (int i = 0; i < 600; i++) begin
            int op;
            bit v;
            v  = ($urandom % 8) != 0;
            op = int'($urandom % 4);
            step(v, int'($urandom % N), op, int'($urandom % N), "R2/R5/R7/R9");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule